// File: doc/BRIEF.md
# Twenty-Round Keystream XOR Core

This core takes a fully assembled 512-bit cipher state of sixteen 32-bit words (constants, key, block counter and nonce) together with one 64-byte data block. On a start strobe it runs twenty rounds of add-rotate-xor mixing over the working copy of the state. It then adds the original state back word by word to form the keystream, and returns the data block XORed with that keystream. The same operation encrypts and decrypts.

The round engine holds four quarter-round units that work side by side on the four columns of the 4x4 word matrix. On alternate cycles the rows are turned by fixed lane rotations, so the same four units work on the diagonals. Key setup, counter stepping between blocks and any bus wrapper belong to the caller. To produce consecutive blocks, the caller adds 0, 1, 2, 3 and so on to word 12.

Top module: `chacha_xor_core`

## Requirements
- R1: While reset is held and after it is released, `done_o` is low and `result_o` is all zeros.
- R2: Each quarter-round on words (a,b,c,d) runs these steps in order, with sums modulo 2^32: a+=b, d=rotl(d^a,16); c+=d, b=rotl(b^c,12); a+=b, d=rotl(d^a,8); c+=d, b=rotl(b^c,7).
- R3: Row r is words 4r..4r+3. A double round applies the quarter-round to columns (i,4+i,8+i,12+i), and then to the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). One round is done per clock.
- R4: Exactly ten double rounds are performed. `done_o` rises on the 21st rising edge after the edge that accepted `start_i`.
- R5: Each keystream word is the final working word plus the matching original input word, modulo 2^32. The carry out of bit 31 is dropped.
- R6: Word i of every 512-bit bus occupies bits [32i+31:32i], so byte 0 is the low byte of word 0. `result_o` equals `data_i` XOR keystream, using the data sampled at the accepting edge.
- R7: `done_o` is high for exactly one cycle per accepted block.
- R8: A `start_i` seen while a block is in progress is ignored. Neither the running result nor its timing changes.
- R9: `result_o` changes only in the cycle `done_o` rises, and holds its value until the next block completes.
- R10: A `start_i` in the same cycle that `done_o` is high is accepted. Blocks can therefore run back to back every 22 cycles.
- R11: Running the core a second time on its own output, with the same state, returns the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a block when idle |
| state_i | input | 512 | Initial state, word i at bits [32i+31:32i] |
| data_i | input | 512 | Data block, same word and byte order |
| result_o | output | 512 | Data XOR keystream, registered |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The completion of one block and the acceptance of the next can fall in the same cycle: `start_i` is sampled on the very edge that follows the `done_o` pulse. The bench provokes this by chaining four blocks with counter offsets 0 to 3, raising `start_i` in each `done_o` cycle. Its per-clock model must then see every later pulse exactly 22 cycles apart, and each result must match the behavioural keystream for its own counter value. A second overlap, a start arriving mid-run, is driven with a different state and judged by checking that the result and pulse timing still belong to the first block.

// File: rtl/chacha_core_pkg.sv
package chacha_core_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 16;
  localparam int ROW_LEN   = 4;
  localparam int BLK_W     = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  // four add-rotate-xor steps on one column or diagonal
  function automatic quad_t mix_quad(input quad_t q);
    quad_t r;
    r = q;
    r.a = r.a + r.b;  r.d = rotl(r.d ^ r.a, 16);
    r.c = r.c + r.d;  r.b = rotl(r.b ^ r.c, 12);
    r.a = r.a + r.b;  r.d = rotl(r.d ^ r.a, 8);
    r.c = r.c + r.d;  r.b = rotl(r.b ^ r.c, 7);
    return r;
  endfunction

  // feed-forward of the original state, then XOR with data
  function automatic logic [BLK_W-1:0] finish_block(input logic [BLK_W-1:0] work,
                                                    input logic [BLK_W-1:0] orig,
                                                    input logic [BLK_W-1:0] dat);
    logic [BLK_W-1:0] r;
    for (int w = 0; w < NUM_WORDS; w++) begin
      r[WORD_W*w +: WORD_W] = dat[WORD_W*w +: WORD_W] ^
                              (work[WORD_W*w +: WORD_W] + orig[WORD_W*w +: WORD_W]);
    end
    return r;
  endfunction
endpackage

// File: rtl/cc_quarter.sv
module cc_quarter
  import chacha_core_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  quad_t q_out;

  assign q_out = mix_quad('{a: a_i, b: b_i, c: c_i, d: d_i});
  assign a_o   = q_out.a;
  assign b_o   = q_out.b;
  assign c_o   = q_out.c;
  assign d_o   = q_out.d;
endmodule

// File: rtl/cc_lane_map.sv
module cc_lane_map
  import chacha_core_pkg::*;
#(
  parameter bit UNDO = 1'b0
) (
  input  logic             rot_i,
  input  logic [BLK_W-1:0] v_i,
  output logic [BLK_W-1:0] v_o
);
  for (genvar r = 0; r < ROW_LEN; r++) begin : g_row
    for (genvar j = 0; j < ROW_LEN; j++) begin : g_lane
      localparam int SRC_L = UNDO ? ((j - r + ROW_LEN) % ROW_LEN) : ((j + r) % ROW_LEN);
      localparam int DST   = ROW_LEN * r + j;
      localparam int SRC   = ROW_LEN * r + SRC_L;
      assign v_o[WORD_W*DST +: WORD_W] = rot_i ? v_i[WORD_W*SRC +: WORD_W]
                                               : v_i[WORD_W*DST +: WORD_W];
    end
  end
endmodule

// File: rtl/cc_round.sv
module cc_round
  import chacha_core_pkg::*;
(
  input  logic             diag_i,
  input  logic [BLK_W-1:0] work_i,
  output logic [BLK_W-1:0] work_o
);
  logic [BLK_W-1:0] turned;
  logic [BLK_W-1:0] mixed;

  cc_lane_map #(.UNDO(1'b0)) fwd_i (.rot_i(diag_i), .v_i(work_i), .v_o(turned));

  for (genvar col = 0; col < ROW_LEN; col++) begin : g_col
    cc_quarter qr_i (
      .a_i(turned[WORD_W*(col)                 +: WORD_W]),
      .b_i(turned[WORD_W*(col + ROW_LEN)       +: WORD_W]),
      .c_i(turned[WORD_W*(col + 2*ROW_LEN)     +: WORD_W]),
      .d_i(turned[WORD_W*(col + 3*ROW_LEN)     +: WORD_W]),
      .a_o(mixed [WORD_W*(col)                 +: WORD_W]),
      .b_o(mixed [WORD_W*(col + ROW_LEN)       +: WORD_W]),
      .c_o(mixed [WORD_W*(col + 2*ROW_LEN)     +: WORD_W]),
      .d_o(mixed [WORD_W*(col + 3*ROW_LEN)     +: WORD_W])
    );
  end

  cc_lane_map #(.UNDO(1'b1)) inv_i (.rot_i(diag_i), .v_i(mixed), .v_o(work_o));
endmodule

// File: rtl/chacha_xor_core.sv
module chacha_xor_core
  import chacha_core_pkg::*;
#(
  parameter int DBL_ROUNDS = 10
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             start_i,
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] data_i,
  output logic [BLK_W-1:0] result_o,
  output logic             done_o
);
  localparam int CNT_W = (DBL_ROUNDS > 1) ? $clog2(DBL_ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DBL_ROUNDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} phase_t;

  phase_t           st;
  logic [BLK_W-1:0] work, orig, dat;
  logic [BLK_W-1:0] next_work;
  logic [CNT_W-1:0] rnd_cnt;
  logic             diag;

  // named events for the checks below
  logic acc_evt, last_evt, fin_evt, busy_start_evt;
  assign acc_evt        = (st == S_IDLE) && start_i;
  assign last_evt       = (st == S_RUN) && diag && (rnd_cnt == LAST_CNT);
  assign fin_evt        = (st == S_FIN);
  assign busy_start_evt = (st != S_IDLE) && start_i;

  cc_round round_i (.diag_i(diag), .work_i(work), .work_o(next_work));

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      st       <= S_IDLE;
      work     <= '0;
      orig     <= '0;
      dat      <= '0;
      rnd_cnt  <= '0;
      diag     <= 1'b0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          orig    <= state_i;
          work    <= state_i;
          dat     <= data_i;
          rnd_cnt <= '0;
          diag    <= 1'b0;
          st      <= S_RUN;
        end
        S_RUN: begin
          work <= next_work;
          diag <= ~diag;
          if (diag) rnd_cnt <= rnd_cnt + 1'b1;
          if (last_evt) st <= S_FIN;
        end
        S_FIN: begin
          result_o <= finish_block(work, orig, dat);
          done_o   <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> !done_o);
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !fin_evt |=> $stable(result_o));
  // R4
  round_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    acc_evt |=> (st == S_RUN) && (rnd_cnt == '0) && !diag);
  // R4
  round_end_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    last_evt |=> fin_evt && !done_o);
  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    busy_start_evt |=> $stable(orig) && $stable(dat));
  // R3
  phase_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st == S_RUN) && !last_evt |=> (st == S_RUN) && (diag != $past(diag)));
endmodule

// File: tb/chacha_xor_core_tb_top.sv
module chacha_xor_core_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [511:0] st_in, dt_in;
  logic [511:0] result;
  logic         done;

  int checks = 0;
  int bad    = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  chacha_xor_core dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .start_i(start),
    .state_i(st_in), .data_i(dt_in), .result_o(result), .done_o(done)
  );

  // ---------- behavioural reference ----------
  function automatic int unsigned rl(int unsigned x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [511:0] ref_block(logic [511:0] s, logic [511:0] d);
    int unsigned x[16];
    int unsigned idx[4];
    logic [511:0] o;
    for (int w = 0; w < 16; w++) x[w] = s[32*w +: 32];
    for (int dr = 0; dr < 10; dr++) begin
      for (int half = 0; half < 2; half++) begin
        for (int c = 0; c < 4; c++) begin
          for (int k = 0; k < 4; k++) idx[k] = 4*k + ((c + half*k) % 4);
          x[idx[0]] += x[idx[1]]; x[idx[3]] = rl(x[idx[3]] ^ x[idx[0]], 16);
          x[idx[2]] += x[idx[3]]; x[idx[1]] = rl(x[idx[1]] ^ x[idx[2]], 12);
          x[idx[0]] += x[idx[1]]; x[idx[3]] = rl(x[idx[3]] ^ x[idx[0]], 8);
          x[idx[2]] += x[idx[3]]; x[idx[1]] = rl(x[idx[1]] ^ x[idx[2]], 7);
        end
      end
    end
    for (int w = 0; w < 16; w++) begin
      int unsigned sum;
      sum = x[w] + s[32*w +: 32];
      o[32*w +: 32] = d[32*w +: 32] ^ sum;
    end
    return o;
  endfunction

  // ---------- cycle model: busy countdown, done and result ----------
  int           mcnt;
  logic         exp_done;
  logic [511:0] exp_res, cap_s, cap_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= 0; exp_done <= 1'b0; exp_res <= '0;
    end else begin
      exp_done <= 1'b0;
      if (mcnt == 0 && start) begin
        mcnt <= 21; cap_s <= st_in; cap_d <= dt_in;
      end else if (mcnt > 0) begin
        mcnt <= mcnt - 1;
        if (mcnt == 1) begin
          exp_done <= 1'b1;
          exp_res  <= ref_block(cap_s, cap_d);
        end
      end
    end
  end

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R4 R7 timing, R9 hold)
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      check(done === exp_done, "R4/R7 done timing", {511'd0, done}, {511'd0, exp_done});
      check(result === exp_res, "R9 result", result, exp_res);
    end
  end

  task automatic finish_up();
    ended = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !ended) begin
      checks++; bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_up();
    end
  end

  // start at this negedge, return at the negedge where done is high
  task automatic run_block(logic [511:0] s, logic [511:0] d);
    st_in = s; dt_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1) @(negedge clk);
  endtask

  function automatic logic [511:0] base_state(int unsigned ctr);
    logic [511:0] s;
    s[31:0] = 32'h61707865; s[63:32] = 32'h3320646e;
    s[95:64] = 32'h79622d32; s[127:96] = 32'h6b206574;
    for (int k = 0; k < 8; k++) s[128 + 32*k +: 32] = 32'h03020100 + k * 32'h04040404;
    s[415:384] = ctr;
    s[447:416] = 32'h09000000; s[479:448] = 32'h4a000000; s[511:480] = 32'h0;
    return s;
  endfunction

  function automatic logic [511:0] pattern(int seed);
    logic [511:0] p;
    for (int b = 0; b < 64; b++) p[8*b +: 8] = 8'(b * 7 + seed);
    return p;
  endfunction

  initial begin
    logic [511:0] s0, d0, r0, prev;
    rst_n = 1'b0; start = 1'b0; st_in = '0; dt_in = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(done === 1'b0 && result === '0, "R1 reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0 && result === '0, "R1 after reset", result, '0);

    // R2 R3 R6: known key, nonce, counter 1
    s0 = base_state(1); d0 = pattern(3);
    run_block(s0, d0);
    r0 = result;
    check(result === ref_block(s0, d0), "R2/R3/R6 keystream", result, ref_block(s0, d0));
    @(negedge clk);

    // R11: second pass restores data
    run_block(s0, r0);
    check(result === d0, "R11 round trip", result, d0);
    @(negedge clk);

    // R6: zero state gives zero keystream, so result equals data
    run_block('0, pattern(11));
    check(result === pattern(11), "R6 zero state", result, pattern(11));
    @(negedge clk);

    // R5: all-ones state exercises the dropped carry
    run_block({512{1'b1}}, '0);
    check(result === ref_block({512{1'b1}}, '0), "R5 wrap add", result, ref_block({512{1'b1}}, '0));
    @(negedge clk);

    // R10: four blocks back to back, start raised in each done cycle
    prev = '0;
    for (int k = 0; k < 4; k++) begin
      run_block(base_state(1 + k), '0);
      check(result === ref_block(base_state(1 + k), '0), "R10 chained block", result,
            ref_block(base_state(1 + k), '0));
      check(result !== prev, "R10 counter step", result, prev);
      prev = result;
    end
    @(negedge clk);

    // R8: start mid-run with another state is ignored
    st_in = s0; dt_in = d0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    st_in = '0; dt_in = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    check(result === ref_block(s0, d0), "R8 busy start ignored", result, ref_block(s0, d0));

    // R9: inputs wander with no start; result holds
    r0 = result;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      st_in = pattern(i); dt_in = pattern(i + 40);
    end
    check(result === r0 && done === 1'b0, "R9 hold", result, r0);

    finish_up();
  end
endmodule